// File: doc/BRIEF.md
# Power-Up Boot Sequencer for an SPI-Attached Wireless Device

This block runs on the host side and brings a wireless device from power-on to a ready state. It does not drive the SPI pins. Instead it issues abstract register reads and writes to a separate SPI transaction engine over a request/acknowledge port. Each request carries a function number, a register address, a write flag and write data. The engine returns read data in the cycle it acknowledges.

When `start` is seen, the sequencer first waits out a power-up delay. The delay length is computed from a clock-frequency parameter, and a small override can shorten it for simulation. The sequencer then keeps reading an identification register until a known pattern comes back, and writes the wake bit. On a cold boot it then polls a low-power-clock status register until the clock is reported available. Next it writes the crystal frequency into the PMU register, which lets the PLL lock. Only after that write is acknowledged does it wait for the chip-active interrupt.

States, in order:
- `S_IDLE`: after reset.
- `S_PWR`: power delay.
- `S_ID`: identification poll.
- `S_WAKE`: wake write.
- `S_LPC`: low-power-clock poll.
- `S_XTAL`: crystal write.
- `S_RDY`: wait for the interrupt.
- `S_DONE` or `S_FAIL`: end states.

Transitions:
- `start` moves `S_IDLE`, `S_DONE` or `S_FAIL` to `S_PWR`.
- Timer expiry moves `S_PWR` to `S_ID`.
- A matching read moves `S_ID` to `S_WAKE`.
- The wake acknowledge moves to `S_LPC` on a cold boot, or to `S_XTAL` otherwise.
- A set clock-available bit moves `S_LPC` to `S_XTAL`.
- The crystal acknowledge moves to `S_RDY`.
- The interrupt moves `S_RDY` to `S_DONE`.
- Phase-timeout expiry moves `S_ID`, `S_LPC` or `S_RDY` to `S_FAIL`.

Top module: `pwrup_boot_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `req_valid` are 0 and `err_code` is 0.
- R2: `start` is sampled at an edge. The first request is then presented exactly DLY+1 cycles later, where DLY is `SIM_DLY` when that is nonzero and otherwise `CLK_HZ/1000*PWRUP_MS`. No request is presented before that.
- R3: The identification poll is a read (`req_write`=0) of function 0 at address 0x14. It is repeated until `rsp_rdata` equals `ID_PATTERN`.
- R4: The read that matches is followed by one write of function 0, address 0x00, data 0x00000080 (bit 7 set, the wake bit).
- R5: With `cold_boot`=1, the wake write is followed by repeated reads of function `LPC_FUNC` (default 1) at `lpc_addr`. These stop once `rsp_rdata & lpc_mask` is nonzero. With `cold_boot`=0 this poll is skipped.
- R6: Next comes one write of function `PMU_FUNC` (default 1) at `pmu_addr` with data `xtal_val`. This is the last request of a successful boot.
- R7: `chip_active_irq` has no effect until the crystal write has been acknowledged. After that, a high `chip_active_irq` sets `done`=1 and `busy`=0.
- R8: Each poll has its own timeout (`to_id`, `to_lpc`, `to_rdy`, counted in cycles from entry to the phase). Expiry sets `err`=1 and `busy`=0, with `err_code` 1 for identification, 2 for the clock poll and 3 for ready. A poll that expires is judged on its next non-matching response.
- R9: `done` and `err` hold until the next `start`. A `start` in either end state reruns the whole sequence from the power delay, and `err_code` reads 0 unless `err` is 1.
- R10: Only one request is outstanding at a time. While `req_valid`=1 and `req_ack`=0, all request fields stay stable. `req_valid` is 0 in the cycle after every acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or restart) the boot sequence |
| cold_boot | input | 1 | 1 = first boot after power-up, poll the low-power clock |
| pmu_addr | input | AW | Address of the PMU crystal-frequency register |
| xtal_val | input | DW | Crystal-frequency value to write |
| lpc_addr | input | AW | Address of the low-power-clock status register |
| lpc_mask | input | DW | Bits that signal the low-power clock is available |
| to_id | input | TO_W | Identification poll timeout, cycles |
| to_lpc | input | TO_W | Low-power-clock poll timeout, cycles |
| to_rdy | input | TO_W | Ready-interrupt timeout, cycles |
| chip_active_irq | input | 1 | Device-ready interrupt, active high |
| req_valid | output | 1 | Request to the SPI transaction engine |
| req_func | output | 2 | Function number |
| req_addr | output | AW | Register address |
| req_write | output | 1 | 1 = write, 0 = read |
| req_wdata | output | DW | Write data |
| req_ack | input | 1 | Engine accepts and completes the request |
| rsp_rdata | input | DW | Read data, valid with `req_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Device ready |
| err | output | 1 | Sequence failed |
| err_code | output | 2 | Failing phase: 1 id, 2 clock, 3 ready |

## Verification
The power delay is the only fixed latency. The bench samples the edge that carries `start`, then counts edges until `req_valid` is seen at a falling edge, and checks that the count equals DLY+1.

Each request is checked against the scoreboard in the cycle the modelled engine raises `req_ack`. Because the responder acknowledges only a request it has already observed, the order of requests is checked regardless of acknowledge latency.

End states are awaited by polling at falling edges, because their cycle depends on the responder's latency and miss counts. Timeouts are judged by the reported code together with the absence of any request beyond the failing phase.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PWR,
        S_ID,
        S_WAKE,
        S_LPC,
        S_XTAL,
        S_RDY,
        S_DONE,
        S_FAIL
    } bstate_t;

    typedef enum logic [1:0] {
        E_NONE = 2'd0,
        E_ID   = 2'd1,
        E_LPC  = 2'd2,
        E_RDY  = 2'd3
    } berr_t;

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R8: once the counter has drained it stays drained until reloaded
    a_r8_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/boot_req_port.sv
module boot_req_port #(
    parameter int AW = 17,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          want,
    input  logic [1:0]    func_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          req_ack,
    output logic          req_valid,
    output logic [1:0]    req_func,
    output logic [AW-1:0] req_addr,
    output logic          req_write,
    output logic [DW-1:0] req_wdata,
    output logic          ack_ok
);

    logic gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= 1'b0;
        end else begin
            gap <= req_valid && req_ack;
        end
    end

    assign req_valid = want && !gap;
    assign req_func  = func_i;
    assign req_addr  = addr_i;
    assign req_write = wr_i;
    assign req_wdata = wdata_i;
    assign ack_ok    = req_valid && req_ack;

    // R10: an unacknowledged request is held with stable fields
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_func) && $stable(req_addr)
                                     && $stable(req_write) && $stable(req_wdata)));

    // R10: the cycle after an acknowledge carries no request
    a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> !req_valid);

endmodule

// File: rtl/pwrup_boot_seq.sv
module pwrup_boot_seq
    import boot_pkg::*;
#(
    parameter int          CLK_HZ     = 100_000_000,
    parameter int          PWRUP_MS   = 50,
    parameter int          SIM_DLY    = 0,
    parameter int          AW         = 17,
    parameter int          DW         = 32,
    parameter int          TO_W       = 16,
    parameter logic [DW-1:0] ID_PATTERN = 32'hBEAD_FEED,
    parameter logic [1:0]  LPC_FUNC   = 2'd1,
    parameter logic [1:0]  PMU_FUNC   = 2'd1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            cold_boot,
    input  logic [AW-1:0]   pmu_addr,
    input  logic [DW-1:0]   xtal_val,
    input  logic [AW-1:0]   lpc_addr,
    input  logic [DW-1:0]   lpc_mask,
    input  logic [TO_W-1:0] to_id,
    input  logic [TO_W-1:0] to_lpc,
    input  logic [TO_W-1:0] to_rdy,
    input  logic            chip_active_irq,
    output logic            req_valid,
    output logic [1:0]      req_func,
    output logic [AW-1:0]   req_addr,
    output logic            req_write,
    output logic [DW-1:0]   req_wdata,
    input  logic            req_ack,
    input  logic [DW-1:0]   rsp_rdata,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [1:0]      err_code
);

    localparam int DLY_CYC = (SIM_DLY != 0) ? SIM_DLY : (CLK_HZ / 1000) * PWRUP_MS;
    localparam int DLY_W   = $clog2(DLY_CYC + 1);
    localparam int CNT_W   = (DLY_W > TO_W) ? DLY_W : TO_W;
    localparam logic [AW-1:0] ID_ADDR   = AW'(20);
    localparam logic [AW-1:0] WAKE_ADDR = '0;
    localparam logic [DW-1:0] WAKE_DATA = DW'(8'h80);

    bstate_t          st, nxt;
    berr_t            ecode, fail_code;
    logic             t_load, t_zero;
    logic [CNT_W-1:0] t_val;
    logic             want, wr_c, ack_ok;
    logic [1:0]       func_c;
    logic [AW-1:0]    addr_c;
    logic [DW-1:0]    wdata_c;

    boot_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .val   (t_val),
        .zero  (t_zero)
    );

    boot_req_port #(.AW(AW), .DW(DW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (want),
        .func_i    (func_c),
        .addr_i    (addr_c),
        .wr_i      (wr_c),
        .wdata_i   (wdata_c),
        .req_ack   (req_ack),
        .req_valid (req_valid),
        .req_func  (req_func),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .ack_ok    (ack_ok)
    );

    // next state and timer control
    always_comb begin
        nxt       = st;
        t_load    = 1'b0;
        t_val     = '0;
        fail_code = E_NONE;
        unique case (st)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start) begin
                    nxt    = S_PWR;
                    t_load = 1'b1;
                    t_val  = CNT_W'(DLY_CYC);
                end
            end
            S_PWR: begin
                if (t_zero) begin
                    nxt    = S_ID;
                    t_load = 1'b1;
                    t_val  = CNT_W'(to_id);
                end
            end
            S_ID: begin
                fail_code = E_ID;
                if (ack_ok) begin
                    if (rsp_rdata == ID_PATTERN) nxt = S_WAKE;
                    else if (t_zero)             nxt = S_FAIL;
                end
            end
            S_WAKE: begin
                if (ack_ok) begin
                    if (cold_boot) begin
                        nxt    = S_LPC;
                        t_load = 1'b1;
                        t_val  = CNT_W'(to_lpc);
                    end else begin
                        nxt = S_XTAL;
                    end
                end
            end
            S_LPC: begin
                fail_code = E_LPC;
                if (ack_ok) begin
                    if ((rsp_rdata & lpc_mask) != '0) nxt = S_XTAL;
                    else if (t_zero)                  nxt = S_FAIL;
                end
            end
            S_XTAL: begin
                if (ack_ok) begin
                    nxt    = S_RDY;
                    t_load = 1'b1;
                    t_val  = CNT_W'(to_rdy);
                end
            end
            S_RDY: begin
                fail_code = E_RDY;
                if (chip_active_irq) nxt = S_DONE;
                else if (t_zero)     nxt = S_FAIL;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // state register and captured error code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            ecode <= E_NONE;
        end else begin
            st <= nxt;
            if (nxt == S_FAIL && st != S_FAIL) ecode <= fail_code;
        end
    end

    // outputs
    always_comb begin
        want    = 1'b0;
        func_c  = 2'd0;
        addr_c  = '0;
        wr_c    = 1'b0;
        wdata_c = '0;
        unique case (st)
            S_ID: begin
                want   = 1'b1;
                addr_c = ID_ADDR;
            end
            S_WAKE: begin
                want    = 1'b1;
                addr_c  = WAKE_ADDR;
                wr_c    = 1'b1;
                wdata_c = WAKE_DATA;
            end
            S_LPC: begin
                want   = 1'b1;
                func_c = LPC_FUNC;
                addr_c = lpc_addr;
            end
            S_XTAL: begin
                want    = 1'b1;
                func_c  = PMU_FUNC;
                addr_c  = pmu_addr;
                wr_c    = 1'b1;
                wdata_c = xtal_val;
            end
            default: ;
        endcase
    end

    assign busy     = (st != S_IDLE) && (st != S_DONE) && (st != S_FAIL);
    assign done     = (st == S_DONE);
    assign err      = (st == S_FAIL);
    assign err_code = err ? ecode : E_NONE;

    // R3/R4: a matching identification response leads to the wake write
    a_r4_wake_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ID && ack_ok && rsp_rdata == ID_PATTERN) |=> (st == S_WAKE));

    // R5: a warm boot skips the clock poll
    a_r5_warm_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAKE && ack_ok && !cold_boot) |=> (st == S_XTAL));

    // R7: ready is only declared on a sampled interrupt
    a_r7_done_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(chip_active_irq));

    // R8: a failure always carries a phase code
    a_r8_code_set: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 2'd0));

    // R9: end states hold without a start
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || err) && !start) |=> $stable(done) && $stable(err));

endmodule

// File: tb/pwrup_boot_seq_tb_top.sv
module pwrup_boot_seq_tb_top;

    localparam int SIM_DLY = 20;
    localparam int AW = 17;
    localparam int DW = 32;
    localparam int TO_W = 16;
    localparam logic [DW-1:0] PAT = 32'hBEAD_FEED;

    typedef struct {
        logic [1:0]    f;
        logic [AW-1:0] a;
        logic          w;
        logic [DW-1:0] d;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cold_boot = 1'b0;
    logic [AW-1:0] pmu_addr = 17'h0_0608;
    logic [DW-1:0] xtal_val = 32'h0000_0A5C;
    logic [AW-1:0] lpc_addr = 17'h0_1E0C;
    logic [DW-1:0] lpc_mask = 32'h0000_0040;
    logic [TO_W-1:0] to_id = 16'd400;
    logic [TO_W-1:0] to_lpc = 16'd400;
    logic [TO_W-1:0] to_rdy = 16'd400;
    logic chip_active_irq = 1'b0;
    logic req_ack = 1'b0;
    logic [DW-1:0] rsp_rdata = '0;
    logic req_valid, req_write, busy, done, err;
    logic [1:0] req_func, err_code;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;

    int vectors = 0;
    int misses = 0;
    bit finished = 0;

    item_t expq[$];
    int id_miss = 0, lpc_miss = 0, id_cnt = 0, lpc_cnt = 0;
    int lat = 1, wait_cnt = 0;
    int irq_dly = 5, irq_cnt = 0;
    bit irq_arm = 0;
    bit xtal_seen = 0;

    always #2.5 clk = ~clk;

    pwrup_boot_seq #(
        .SIM_DLY(SIM_DLY), .AW(AW), .DW(DW), .TO_W(TO_W), .ID_PATTERN(PAT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cold_boot(cold_boot),
        .pmu_addr(pmu_addr), .xtal_val(xtal_val), .lpc_addr(lpc_addr),
        .lpc_mask(lpc_mask), .to_id(to_id), .to_lpc(to_lpc), .to_rdy(to_rdy),
        .chip_active_irq(chip_active_irq), .req_valid(req_valid),
        .req_func(req_func), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .busy(busy), .done(done), .err(err), .err_code(err_code)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] f, input logic [AW-1:0] a,
                        input logic w, input logic [DW-1:0] d);
        item_t it;
        it.f = f; it.a = a; it.w = w; it.d = d;
        expq.push_back(it);
    endtask

    task automatic model_reset();
        expq.delete();
        id_cnt = 0; lpc_cnt = 0; irq_arm = 0; irq_cnt = 0;
        chip_active_irq = 1'b0; xtal_seen = 0;
    endtask

    // scoreboard monitor and engine model: compares each request as it is acknowledged
    initial begin
        forever begin
            @(negedge clk);
            if (req_ack) begin
                req_ack = 1'b0;
            end else if (req_valid && rst_n) begin
                if (wait_cnt < lat) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    if (expq.size() == 0) begin
                        chk(1'b0, "R10 unexpected request", {req_func, req_addr}, 0);
                    end else begin
                        item_t e;
                        e = expq.pop_front();
                        chk(req_func == e.f && req_addr == e.a && req_write == e.w
                            && (!e.w || req_wdata == e.d),
                            "R3-R6 request order",
                            {req_func, req_addr, req_write, req_wdata},
                            {e.f, e.a, e.w, e.d});
                    end
                    rsp_rdata = '0;
                    if (!req_write && req_func == 2'd0 && req_addr == 17'h14) begin
                        rsp_rdata = (id_cnt < id_miss) ? 32'h0 : PAT;
                        id_cnt++;
                    end else if (!req_write && req_func == 2'd1 && req_addr == lpc_addr) begin
                        rsp_rdata = (lpc_cnt < lpc_miss) ? 32'h0000_0001 : lpc_mask;
                        lpc_cnt++;
                    end else if (req_write && req_func == 2'd1 && req_addr == pmu_addr) begin
                        irq_arm = 1;
                        xtal_seen = 1;
                    end
                    req_ack = 1'b1;
                end
            end
        end
    end

    // device ready interrupt model
    initial begin
        forever begin
            @(negedge clk);
            if (irq_arm) begin
                if (irq_cnt >= irq_dly) chip_active_irq = 1'b1;
                else irq_cnt++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            misses++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic pulse_start(output int n);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        n = 0;
        while (!req_valid && n < 1000) begin
            @(posedge clk);
            n++;
            #1;
        end
    endtask

    task automatic wait_end();
        int k = 0;
        while (!(done || err) && k < 5000) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
    endtask

    initial begin
        int n;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !err && !req_valid && err_code == 0, "R1 reset outputs",
            {busy, done, err, req_valid, err_code}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !req_valid, "R1 idle without start", {busy, req_valid}, 0);

        // cold boot with misses
        model_reset();
        id_miss = 2; lpc_miss = 2; irq_dly = 5; lat = 1; cold_boot = 1'b1;
        repeat (3) push(2'd0, 17'h14, 1'b0, 0);
        push(2'd0, 17'h00, 1'b1, 32'h80);
        repeat (3) push(2'd1, lpc_addr, 1'b0, 0);
        push(2'd1, pmu_addr, 1'b1, xtal_val);
        pulse_start(n);
        chk(n == SIM_DLY + 1, "R2 power delay cycles", n, SIM_DLY + 1);
        wait_end();
        chk(done && !err && !busy, "R7 cold boot done", {done, err, busy}, 3'b100);
        chk(expq.size() == 0, "R5 cold boot sequence complete", expq.size(), 0);

        // warm boot restarted from done, no clock poll
        model_reset();
        id_miss = 0; cold_boot = 1'b0; lat = 3;
        push(2'd0, 17'h14, 1'b0, 0);
        push(2'd0, 17'h00, 1'b1, 32'h80);
        push(2'd1, pmu_addr, 1'b1, xtal_val);
        pulse_start(n);
        chk(n == SIM_DLY + 1, "R9 restart from done reruns power delay", n, SIM_DLY + 1);
        wait_end();
        chk(done && !err, "R5 warm boot done", {done, err}, 2'b10);
        chk(expq.size() == 0, "R6 warm boot sequence complete", expq.size(), 0);
        chk(err_code == 0, "R9 no code on success", err_code, 0);

        // interrupt asserted early must be ignored until the crystal write
        model_reset();
        id_miss = 1; lat = 0;
        chip_active_irq = 1'b1;
        repeat (2) push(2'd0, 17'h14, 1'b0, 0);
        push(2'd0, 17'h00, 1'b1, 32'h80);
        push(2'd1, pmu_addr, 1'b1, xtal_val);
        pulse_start(n);
        chk(!done, "R7 early irq no done during sequence", done, 0);
        wait_end();
        chk(done && xtal_seen, "R7 done only after crystal write", {done, xtal_seen}, 2'b11);
        chk(expq.size() == 0, "R7 crystal write issued", expq.size(), 0);

        // identification timeout
        model_reset();
        id_miss = 100000; lat = 1; to_id = 16'd6;
        repeat (200) push(2'd0, 17'h14, 1'b0, 0);
        pulse_start(n);
        wait_end();
        chk(err && !busy && !done && err_code == 2'd1, "R8 id timeout code",
            {err, busy, done, err_code}, {3'b100, 2'd1});
        to_id = 16'd400;

        // clock poll timeout
        model_reset();
        id_miss = 0; lpc_miss = 100000; cold_boot = 1'b1; to_lpc = 16'd8;
        push(2'd0, 17'h14, 1'b0, 0);
        push(2'd0, 17'h00, 1'b1, 32'h80);
        repeat (200) push(2'd1, lpc_addr, 1'b0, 0);
        pulse_start(n);
        wait_end();
        chk(err && err_code == 2'd2, "R8 clock poll timeout code", {err, err_code}, {1'b1, 2'd2});
        to_lpc = 16'd400;

        // ready timeout, then sticky error
        model_reset();
        cold_boot = 1'b0; irq_dly = 100000; to_rdy = 16'd8;
        push(2'd0, 17'h14, 1'b0, 0);
        push(2'd0, 17'h00, 1'b1, 32'h80);
        push(2'd1, pmu_addr, 1'b1, xtal_val);
        pulse_start(n);
        wait_end();
        chk(err && err_code == 2'd3, "R8 ready timeout code", {err, err_code}, {1'b1, 2'd3});
        chk(expq.size() == 0, "R6 crystal written before ready wait", expq.size(), 0);
        repeat (10) @(negedge clk);
        chk(err && !req_valid && err_code == 2'd3, "R9 error sticky", {err, req_valid, err_code},
            {1'b1, 1'b0, 2'd3});

        // restart from fail succeeds
        model_reset();
        irq_dly = 2; to_rdy = 16'd400;
        push(2'd0, 17'h14, 1'b0, 0);
        push(2'd0, 17'h00, 1'b1, 32'h80);
        push(2'd1, pmu_addr, 1'b1, xtal_val);
        pulse_start(n);
        chk(n == SIM_DLY + 1, "R9 restart from fail", n, SIM_DLY + 1);
        wait_end();
        chk(done && !err && err_code == 0, "R9 recovered boot", {done, err, err_code}, 4'b1000);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule